// File: doc/BRIEF.md
# SD Host Block-Transfer Sequencer

This block sits inside an SD/MMC host controller, between the software register port and the data path. Software sets the transfer options: whether to move one block or many, whether the count register bounds the transfer, whether a stop command follows the final block automatically, whether DMA is used, and which way data flows. It also sets a 16-bit block count. A byte write to the high byte of the command register starts a transfer. At that moment the sequencer classifies the transfer into one of four kinds and either finishes at once or goes busy.

While busy, the sequencer takes one-cycle block-complete pulses from the data path. For a counted transfer it decrements the count on each pulse. It ends a transfer with a one-cycle done pulse. When the transfer was counted and auto-stop is on, it raises an auto-stop pulse at the same time. An endless transfer ends only after an external stop request, at the next block boundary. A one-cycle DMA start pulse marks the start of a data transfer when DMA is enabled and the build supports DMA.

All pins are plain control and status signals with no data stream, so there is no valid/ready handshake. Every write is accepted in the cycle it appears, or dropped when the lockout rule applies. Reads are combinational from the address.

Top module: `sd_xfer_sequencer`

## Requirements
- R1: After reset the mode byte, block count and command registers read 0, and xfer_active, xfer_done, auto_stop_req and dma_start are low.
- R2: When mode bit 0 (multi) is 0, a start makes a single-block transfer, xfer_kind 0. It ends on the first block pulse with xfer_done high in the next cycle. The count and the count-enable bit have no effect, and the count is left unchanged.
- R3: Multi=1 with count-enable (mode bit 2) at 0 gives an endless transfer, xfer_kind 1. Its count is not changed. A stop_req pulse marks it to end, and it ends on the first block pulse at or after the stop request.
- R4: Multi=1, count-enable=1 and a nonzero count give a counted transfer, xfer_kind 2. Each block pulse decrements the count by one, and the transfer ends on the pulse that brings it to 0.
- R5: Multi=1, count-enable=1 and a count of 0 give a halt, xfer_kind 3. xfer_done pulses in the cycle after the start write, and xfer_active and dma_start stay low.
- R6: auto_stop_req is a one-cycle pulse that coincides with xfer_done only at the end of a counted transfer with mode bit 3 (auto-stop) set. It never appears for single, endless or halt transfers.
- R7: A write to address 0x0F starts a transfer. When mode bit 4 (DMA enable) is set, dma_start pulses for one cycle in the cycle after that write, for single, endless and counted kinds. A write to 0x0E starts nothing.
- R8: With DMA_SUPPORTED=0, mode bit 4 always reads 0 and dma_start never rises.
- R9: xfer_rd equals mode bit 1: 1 means card to host (read), 0 means host to card (write).
- R10: While xfer_active is high, writes to the count bytes (0x04 low, 0x05 high), the mode byte (0x0C) and the command bytes (0x0E, 0x0F) are ignored, so they neither change the readback nor start a transfer.
- R11: Block pulses and stop requests while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register byte write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Combinational read data |
| blk_done | input | 1 | One-cycle block-complete pulse from the data path |
| stop_req | input | 1 | Request to end an endless transfer |
| xfer_active | output | 1 | Transfer in progress |
| xfer_kind | output | 2 | Kind of the latest transfer: 0 single, 1 endless, 2 counted, 3 halt |
| xfer_rd | output | 1 | Direction, 1 = card to host |
| xfer_done | output | 1 | One-cycle end-of-transfer pulse |
| auto_stop_req | output | 1 | One-cycle request to issue the stop command |
| dma_start | output | 1 | One-cycle DMA start pulse |

## Verification
The hardest cases to reach are the ones where the sequencer must ignore an event that arrives in the same window as a real one. Examples are a stop request that lands in the same cycle as the block pulse that should end an endless transfer, and register writes that arrive while a counted transfer is partway through its count. The stimulus issues writes to every register, including 0x0F, between block pulses of a counted transfer. It also drives stop_req and blk_done together. It runs block pulses back to back on every cycle, so that the decrement and the end-of-count decision follow each other without idle cycles.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_CNT_BASE = 8'h04;
  localparam logic [ADDR_W-1:0] A_MODE     = 8'h0C;
  localparam logic [ADDR_W-1:0] A_CMD_LO   = 8'h0E;
  localparam logic [ADDR_W-1:0] A_CMD_HI   = 8'h0F;

  typedef enum logic [1:0] {
    XK_SINGLE  = 2'd0,
    XK_ENDLESS = 2'd1,
    XK_COUNTED = 2'd2,
    XK_HALT    = 2'd3
  } xfer_kind_e;

  typedef struct packed {
    logic dma_en;
    logic auto_stop;
    logic cnt_en;
    logic dir_rd;
    logic multi;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);
endpackage

// File: rtl/sdx_regs.sv
module sdx_regs
  import sdx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit DMA_OK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              busy,
  input  logic              dec,
  output mode_t             mode,
  output logic [CNT_W-1:0]  blk_cnt,
  output logic              start
);
  localparam int CNT_BYTES = CNT_W / BYTE_W;
  localparam int CMD_W     = 2 * BYTE_W;

  logic              wr_ok;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CMD_W-1:0]  cmd_q;

  assign wr_ok = wr_en && !busy;
  assign start = wr_ok && (wr_addr == A_CMD_HI);

  always_comb begin
    cnt_nxt = blk_cnt;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (wr_ok && (wr_addr == A_CNT_BASE + ADDR_W'(i)))
        cnt_nxt[i*BYTE_W +: BYTE_W] = wr_data;
    end
    if (dec && (blk_cnt != '0))
      cnt_nxt = blk_cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_cnt <= '0;
      mode    <= '0;
      cmd_q   <= '0;
    end else begin
      blk_cnt <= cnt_nxt;
      if (wr_ok && wr_addr == A_MODE) begin
        mode        <= mode_t'(wr_data[MODE_W-1:0]);
        mode.dma_en <= wr_data[MODE_W-1] & DMA_OK;
      end
      if (wr_ok && wr_addr == A_CMD_LO) cmd_q[BYTE_W-1:0]     <= wr_data;
      if (start)                        cmd_q[CMD_W-1:BYTE_W] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < CNT_BYTES; i++) begin
      if (rd_addr == A_CNT_BASE + ADDR_W'(i))
        rd_data = blk_cnt[i*BYTE_W +: BYTE_W];
    end
    if (rd_addr == A_MODE)   rd_data = BYTE_W'(mode);
    if (rd_addr == A_CMD_LO) rd_data = cmd_q[BYTE_W-1:0];
    if (rd_addr == A_CMD_HI) rd_data = cmd_q[CMD_W-1:BYTE_W];
  end

  // R10: settings stay frozen through a transfer
  a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mode));
  // R4: one decrement per accepted block
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec) && ($past(blk_cnt) != '0) |-> blk_cnt == $past(blk_cnt) - CNT_W'(1));
  // R4: saturation at zero
  a_r4_count_floor: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dec) && ($past(blk_cnt) == '0) |-> blk_cnt == '0);
  // R8: DMA bit cannot be held without support
  a_r8_dma_bit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !DMA_OK |-> !mode.dma_en);
endmodule

// File: rtl/sdx_ctrl.sv
module sdx_ctrl
  import sdx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  mode_t            mode,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic             blk_done,
  input  logic             stop_req,
  output logic             busy,
  output xfer_kind_e       kind,
  output logic             dec,
  output logic             done,
  output logic             auto_stop,
  output logic             dma_go
);
  xfer_kind_e start_kind;
  logic       stop_pend;
  logic       last_blk;

  always_comb begin
    if (!mode.multi)         start_kind = XK_SINGLE;
    else if (!mode.cnt_en)   start_kind = XK_ENDLESS;
    else if (blk_cnt != '0)  start_kind = XK_COUNTED;
    else                     start_kind = XK_HALT;
  end

  assign dec      = busy && (kind == XK_COUNTED) && blk_done;
  assign last_blk = (blk_cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      kind      <= XK_SINGLE;
      stop_pend <= 1'b0;
      done      <= 1'b0;
      auto_stop <= 1'b0;
      dma_go    <= 1'b0;
    end else begin
      done      <= 1'b0;
      auto_stop <= 1'b0;
      dma_go    <= 1'b0;
      if (!busy) begin
        if (start) begin
          kind <= start_kind;
          if (start_kind == XK_HALT) begin
            done <= 1'b1;
          end else begin
            busy   <= 1'b1;
            dma_go <= mode.dma_en;
          end
        end
      end else begin
        if (stop_req && kind == XK_ENDLESS) stop_pend <= 1'b1;
        if (blk_done) begin
          unique case (kind)
            XK_SINGLE: begin
              busy <= 1'b0;
              done <= 1'b1;
            end
            XK_ENDLESS: begin
              if (stop_pend || stop_req) begin
                busy      <= 1'b0;
                done      <= 1'b1;
                stop_pend <= 1'b0;
              end
            end
            XK_COUNTED: begin
              if (last_blk) begin
                busy      <= 1'b0;
                done      <= 1'b1;
                auto_stop <= mode.auto_stop;
              end
            end
            default: begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R6: the stop request only rides on an end of transfer
  a_r6_stop_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    auto_stop |-> done);
  // R6: single-cycle request
  a_r6_stop_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    auto_stop |=> !auto_stop);
  // R7: DMA start only follows an accepted start write
  a_r7_dma_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    dma_go |-> $past(start) && !$past(busy));
  // R2: completion leaves the sequencer idle
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R11: an idle block pulse without a start changes nothing
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy && !done);
endmodule

// File: rtl/sd_xfer_sequencer.sv
module sd_xfer_sequencer
  import sdx_pkg::*;
#(
  parameter int CNT_W         = 16,
  parameter bit DMA_SUPPORTED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_addr,
  output logic [7:0] rd_data,
  input  logic       blk_done,
  input  logic       stop_req,
  output logic       xfer_active,
  output logic [1:0] xfer_kind,
  output logic       xfer_rd,
  output logic       xfer_done,
  output logic       auto_stop_req,
  output logic       dma_start
);
  mode_t            mode;
  logic [CNT_W-1:0] blk_cnt;
  logic             start;
  logic             dec;
  xfer_kind_e       kind;

  sdx_regs #(.CNT_W(CNT_W), .DMA_OK(DMA_SUPPORTED)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .busy    (xfer_active),
    .dec     (dec),
    .mode    (mode),
    .blk_cnt (blk_cnt),
    .start   (start)
  );

  sdx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .blk_cnt   (blk_cnt),
    .blk_done  (blk_done),
    .stop_req  (stop_req),
    .busy      (xfer_active),
    .kind      (kind),
    .dec       (dec),
    .done      (xfer_done),
    .auto_stop (auto_stop_req),
    .dma_go    (dma_start)
  );

  assign xfer_kind = kind;
  assign xfer_rd   = mode.dir_rd;

  // R9: direction output tracks the stored mode bit
  a_r9_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_active && $past(xfer_active) |-> $stable(xfer_rd));
  // R8: no DMA pulse in a build without DMA
  a_r8_no_dma: assert property (@(posedge clk) disable iff (!rst_n)
    !DMA_SUPPORTED |-> !dma_start);
endmodule

// File: tb/sd_xfer_sequencer_tb.sv
module sd_xfer_sequencer_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, wr_en = 1'b0, blk_done = 1'b0, stop_req = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data, nd_rd_data;
  logic       act, rd_dir, done, as_req, dma, nd_act, nd_rd_dir, nd_done, nd_as, nd_dma;
  logic [1:0] kind, nd_kind;

  sd_xfer_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .blk_done(blk_done), .stop_req(stop_req),
    .xfer_active(act), .xfer_kind(kind), .xfer_rd(rd_dir), .xfer_done(done),
    .auto_stop_req(as_req), .dma_start(dma));

  sd_xfer_sequencer #(.DMA_SUPPORTED(1'b0)) u_nodma (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(nd_rd_data), .blk_done(blk_done), .stop_req(stop_req),
    .xfer_active(nd_act), .xfer_kind(nd_kind), .xfer_rd(nd_rd_dir), .xfer_done(nd_done),
    .auto_stop_req(nd_as), .dma_start(nd_dma));

  int total = 0, bad = 0;

  task automatic chk(string tag, string what, logic [31:0] actual, logic [31:0] expected);
    total++;
    if (actual !== expected) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  // behavioural reference
  logic [4:0]  m_mode = '0;
  logic [15:0] m_cnt = '0, m_cmd = '0;
  bit          m_act, m_pend, e_done, e_as, e_dma;
  logic [1:0]  m_kind = '0;

  always @(posedge clk) begin
    bit was_act;
    e_done = 0; e_as = 0; e_dma = 0;
    if (!rst_n) begin
      m_mode = '0; m_cnt = '0; m_cmd = '0; m_act = 0; m_pend = 0; m_kind = 0;
    end else begin
      was_act = m_act;
      if (was_act) begin
        if (stop_req && m_kind == 1) m_pend = 1;
        if (blk_done) begin
          if (m_kind == 0) begin m_act = 0; e_done = 1; end
          else if (m_kind == 1) begin
            if (m_pend) begin m_act = 0; e_done = 1; m_pend = 0; end
          end else begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin m_act = 0; e_done = 1; e_as = m_mode[3]; end
          end
        end
      end else if (wr_en) begin
        case (wr_addr)
          8'h04: m_cnt[7:0] = wr_data;
          8'h05: m_cnt[15:8] = wr_data;
          8'h0C: m_mode = wr_data[4:0];
          8'h0E: m_cmd[7:0] = wr_data;
          8'h0F: begin
            m_cmd[15:8] = wr_data;
            if (!m_mode[0]) m_kind = 0;
            else if (!m_mode[2]) m_kind = 1;
            else if (m_cnt != 0) m_kind = 2;
            else m_kind = 3;
            if (m_kind == 3) e_done = 1;
            else begin m_act = 1; e_dma = m_mode[4]; end
          end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_rd(logic [7:0] a, bit nodma);
    case (a)
      8'h04: return m_cnt[7:0];
      8'h05: return m_cnt[15:8];
      8'h0C: return nodma ? {3'b0, 1'b0, m_mode[3:0]} : {3'b0, m_mode};
      8'h0E: return m_cmd[7:0];
      8'h0F: return m_cmd[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R4/R5", "xfer_done", done, e_done);
      chk("R3/R11", "xfer_active", act, m_act);
      chk("R3", "xfer_kind", kind, m_kind);
      chk("R6", "auto_stop_req", as_req, e_as);
      chk("R7", "dma_start", dma, e_dma);
      chk("R9", "xfer_rd", rd_dir, m_mode[1]);
      chk("R10", "rd_data", rd_data, exp_rd(rd_addr, 0));
      chk("R8", "nodma dma_start", nd_dma, 1'b0);
      chk("R8", "nodma rd_data", nd_rd_data, exp_rd(rd_addr, 1));
      chk("R8", "nodma done", nd_done, e_done);
    end
  end

  int rd_idx = 0;
  task automatic cyc();
    @(posedge clk); #2;
    rd_idx = (rd_idx + 1) % 6;
    case (rd_idx)
      0: rd_addr = 8'h04; 1: rd_addr = 8'h05; 2: rd_addr = 8'h0C;
      3: rd_addr = 8'h0E; 4: rd_addr = 8'h0F; default: rd_addr = 8'h33;
    endcase
  endtask
  task automatic wr(logic [7:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; cyc(); wr_en = 0;
  endtask
  task automatic blk();
    blk_done = 1; cyc(); blk_done = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask
  task automatic setup(logic [15:0] c, logic [7:0] md);
    wr(8'h04, c[7:0]); wr(8'h05, c[15:8]); wr(8'h0C, md); wr(8'h0E, 8'h12);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R1: reset state
    chk("R1", "active", act, 0);
    chk("R1", "done", done, 0);
    chk("R1", "dma", dma, 0);
    rd_addr = 8'h0C; #1; chk("R1", "mode", rd_data, 0);
    rd_addr = 8'h04; #1; chk("R1", "count", rd_data, 0);

    // R11: block and stop while idle
    stop_req = 1; blk(); stop_req = 0;
    chk("R11", "active after idle block", act, 0);
    chk("R11", "done after idle block", done, 0);

    // R2: single block, count enable and count set, read, DMA
    setup(16'd5, 8'b1_0110);
    wr(8'h0F, 8'hA1);
    chk("R2", "single active", act, 1);
    chk("R7", "dma pulse", dma, 1);
    idle(2);
    blk();
    chk("R2", "single done", done, 1);
    rd_addr = 8'h04; #1; chk("R2", "count kept", rd_data, 5);
    idle(2);

    // R7: low command byte starts nothing
    wr(8'h0E, 8'h55);
    chk("R7", "no start on low byte", act, 0);

    // R4/R6/R10: counted with auto-stop and writes during the run
    setup(16'd3, 8'b0_1101);
    wr(8'h0F, 8'h02);
    chk("R7", "no dma when disabled", dma, 0);
    blk();
    wr(8'h0C, 8'h00); wr(8'h04, 8'h09); wr(8'h05, 8'h01); wr(8'h0E, 8'hFF); wr(8'h0F, 8'hFF);
    chk("R10", "still active", act, 1);
    blk(); idle(1);
    blk();
    chk("R4", "counted done", done, 1);
    chk("R6", "auto stop", as_req, 1);
    idle(2);

    // R3: endless, stop together with block
    setup(16'd2, 8'b1_1001);
    wr(8'h0F, 8'h03);
    chk("R3", "endless kind", kind, 1);
    repeat (4) blk();
    chk("R3", "endless still active", act, 1);
    stop_req = 1; blk_done = 1; cyc(); stop_req = 0; blk_done = 0;
    chk("R3", "endless ends", done, 1);
    chk("R6", "no auto stop endless", as_req, 0);
    idle(2);

    // R3: stop early, end at the next block
    wr(8'h0F, 8'h04);
    stop_req = 1; cyc(); stop_req = 0;
    idle(2);
    chk("R3", "waits for block", act, 1);
    blk();
    chk("R3", "ended at block", done, 1);

    // R5: halt with zero count
    setup(16'd0, 8'b1_0101);
    wr(8'h0F, 8'h05);
    chk("R5", "halt done", done, 1);
    chk("R5", "halt idle", act, 0);
    chk("R5", "halt no dma", dma, 0);
    idle(2);

    // R4: back-to-back blocks, no auto-stop, multi-byte count
    setup(16'h0104, 8'b0_0111);
    wr(8'h0F, 8'h06);
    repeat (259) blk();
    chk("R4", "one block left", act, 1);
    blk();
    chk("R4", "count reached zero", done, 1);
    chk("R6", "no auto stop when off", as_req, 0);
    idle(3);

    finish_run();
  end
endmodule